// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is a single output cell of a sum-of-products logic device. The array outside it supplies one sum-term bit and one output-enable term. The cell turns them into a pin drive: a value plus a tri-state enable. It also returns a feedback bit, in true and complement form, to the array. A 4-bit configuration word sets four things: registered or combinatorial operation, pin polarity, which of two clocks drives the internal flip-flop, and where the feedback is taken from.

The flip-flop has several controls. A shared reset term clears it at once. A shared preset term sets it on the next selected clock edge. A preload path forces any chosen value on that edge, so that state sequences can be tested from arbitrary states. A power-on input clears it as well. The flip-flop keeps capturing the sum term in combinatorial mode, so buried feedback can supply a registered copy of a combinatorial output.

Top module: `olmc_cell`

## Requirements
- R1: With cfg[1]=0 (registered), the flip-flop loads sum_in on each rising edge of the selected clock, and pin_out equals Q when cfg[0]=0 and the inverse of Q when cfg[0]=1.
- R2: With cfg[1]=1 (combinatorial), pin_out equals sum_in XOR cfg[0] in the same cycle, with no clock edge needed.
- R3: cfg[2]=1 clocks the flip-flop from clk1 and cfg[2]=0 clocks it from clk2; edges on the clock that is not selected leave Q unchanged.
- R4: Buried feedback (fb_true = inverse of Q) is chosen when cfg[1]=0 and cfg[3]=1, or when cfg[1]=1 and cfg[3]=0; in the other two settings fb_true is the pin level.
- R5: fb_comp is always the inverse of fb_true.
- R6: The pin level used for feedback is pin_out while pin_oe=1 and pin_in while pin_oe=0.
- R7: oe_mode 2'b00 holds pin_oe at 0, 2'b01 holds it at 1, and 2'b10 or 2'b11 makes pin_oe follow oe_term.
- R8: While ar_term or por is 1, Q is 0 at once without a clock edge, and this overrides preset and preload; the pin then shows cfg[0] in registered mode.
- R9: With sp_term=1 and pl_en=0 at a selected rising edge, Q becomes 1.
- R10: With pl_en=1 at a selected rising edge, Q becomes pl_val, whatever sp_term and sum_in are.
- R11: In combinatorial mode the flip-flop keeps loading sum_in on the selected clock, and this shows on the buried feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1 | input | 1 | First clock source |
| clk2 | input | 1 | Second clock source |
| por | input | 1 | Power-on clear, active high, asynchronous |
| sum_in | input | 1 | Sum-term bit from the array |
| oe_term | input | 1 | Output-enable product term |
| oe_mode | input | 2 | Enable source: 00 off, 01 on, 1x from oe_term |
| ar_term | input | 1 | Shared asynchronous reset term |
| sp_term | input | 1 | Shared synchronous preset term |
| cfg | input | 4 | [0] invert, [1] combinatorial, [2] clk1 select, [3] feedback select |
| pl_en | input | 1 | Preload enable |
| pl_val | input | 1 | Preload value |
| pin_in | input | 1 | Level seen on the pin from outside |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_true | output | 1 | Feedback bit to the array |
| fb_comp | output | 1 | Complement of the feedback bit |

## Verification
The cell has no parameters, so the bench builds it as written. Every mode combination is reachable at run time through cfg and oe_mode. clk2 runs at a quarter of the clk1 rate, so with clk2 selected there are whole clk1 cycles in which Q must hold while clk1 still toggles. The bench also pulses the reset term between clock edges while preset and preload are active, to expose the immediate clear and its priority.

// File: rtl/olmc_cell.sv
module olmc_cell (
  input  logic       clk1,
  input  logic       clk2,
  input  logic       por,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic [1:0] oe_mode,
  input  logic       ar_term,
  input  logic       sp_term,
  input  logic [3:0] cfg,
  input  logic       pl_en,
  input  logic       pl_val,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_true,
  output logic       fb_comp
);

  logic q;
  logic rclk;
  logic clr;
  logic comb_mode;
  logic use_buried;
  logic pin_level;

  assign rclk      = cfg[2] ? clk1 : clk2;
  assign clr       = ar_term | por;
  assign comb_mode = cfg[1];

  always_ff @(posedge rclk or posedge clr) begin
    if (clr)        q <= 1'b0;
    else if (pl_en) q <= pl_val;
    else if (sp_term) q <= 1'b1;
    else            q <= sum_in;
  end

  assign pin_out = (comb_mode ? sum_in : q) ^ cfg[0];

  always_comb begin
    unique case (oe_mode)
      2'b00:   pin_oe = 1'b0;
      2'b01:   pin_oe = 1'b1;
      default: pin_oe = oe_term;
    endcase
  end

  assign pin_level  = pin_oe ? pin_out : pin_in;
  assign use_buried = comb_mode ^ cfg[3];
  assign fb_true    = use_buried ? ~q : pin_level;
  assign fb_comp    = ~fb_true;

  assert_capture_R1: assert property (@(posedge rclk) disable iff (clr)
    (!pl_en && !sp_term) |=> (q == $past(sum_in)));

  assert_preset_R9: assert property (@(posedge rclk) disable iff (clr)
    (sp_term && !pl_en) |=> q);

  assert_preload_R10: assert property (@(posedge rclk) disable iff (clr)
    pl_en |=> (q == $past(pl_val)));

  assert_clear_R8: assert property (@(posedge clk1)
    clr |-> (q == 1'b0));

endmodule

// File: tb/test_olmc_cell.sv
module test_olmc_cell;
  logic       clk1 = 0, clk2 = 0, ph = 0;
  logic       por = 0, sum_in = 0, oe_term = 0, ar_term = 0, sp_term = 0;
  logic       pl_en = 0, pl_val = 0, pin_in = 0;
  logic [1:0] oe_mode = 2'b01;
  logic [3:0] cfg = 4'b0100;
  logic       pin_out, pin_oe, fb_true, fb_comp;
  logic       mq = 0;
  int         checks = 0, errors = 0;
  bit         done = 0;

  olmc_cell i_olmc_cell (
    .clk1(clk1), .clk2(clk2), .por(por), .sum_in(sum_in), .oe_term(oe_term),
    .oe_mode(oe_mode), .ar_term(ar_term), .sp_term(sp_term), .cfg(cfg),
    .pl_en(pl_en), .pl_val(pl_val), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp));

  // 125 MHz clk1; clk2 at a quarter rate, edges aligned to clk1 rising edges
  initial forever begin
    #4;
    clk1 = 1;
    ph = ~ph;
    if (ph) clk2 = ~clk2;
    if (cfg[2] || (ph && clk2)) begin
      if (por || ar_term) mq = 0;
      else if (pl_en)     mq = pl_val;
      else if (sp_term)   mq = 1;
      else                mq = sum_in;
    end
    #4;
    clk1 = 0;
  end

  task automatic tick();
    @(negedge clk1);
  endtask

  task automatic safe_tick();
    do @(negedge clk1); while (clk2);
  endtask

  task automatic chk(input string tag);
    logic eo, eoe, lvl, buried, efb;
    #1;
    if (por || ar_term) mq = 0;
    eo     = (cfg[1] ? sum_in : mq) ^ cfg[0];
    eoe    = (oe_mode == 2'b00) ? 1'b0 : (oe_mode == 2'b01) ? 1'b1 : oe_term;
    lvl    = eoe ? eo : pin_in;
    buried = (!cfg[1] && cfg[3]) || (cfg[1] && !cfg[3]);
    efb    = buried ? ~mq : lvl;
    checks++;
    if ({pin_out, pin_oe, fb_true} !== {eo, eoe, efb}) begin
      errors++;
      $display("FAIL %s out/oe/fb actual %b%b%b expected %b%b%b", tag,
               pin_out, pin_oe, fb_true, eo, eoe, efb);
    end
    checks++;
    if (fb_comp !== ~fb_true) begin
      errors++;
      $display("FAIL R5 fb_comp actual %b expected %b", fb_comp, ~fb_true);
    end
  endtask

  initial begin
    #(8*20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 por = 1;
    // R8: power-up clear, both polarities
    repeat (3) begin tick(); sum_in = 1; chk("R8"); end
    tick(); cfg[0] = 1; chk("R8");
    tick(); por = 0; cfg = 4'b0100; chk("R8");

    // R1: registered mode on clk1, both polarities
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 12; i++) begin
        tick(); cfg[0] = p[0]; sum_in = ((i * 5 + 3) % 7) > 3; chk("R1");
      end

    // R2: combinatorial mode follows sum_in at once
    for (int i = 0; i < 8; i++) begin
      tick(); cfg = {3'b010, i[0]}; sum_in = i[1]; chk("R2");
    end

    // R3: clk2 selected, clk1 edges must not load
    safe_tick(); cfg = 4'b0000; chk("R3");
    for (int i = 0; i < 16; i++) begin
      tick(); sum_in = ((i * 3) % 5) > 1; chk("R3");
    end
    safe_tick(); cfg = 4'b0100; chk("R3");

    // R4/R6/R7: feedback source versus mode, select bit and enable
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 4; m++) begin
        safe_tick();
        cfg = {c[3], 1'b1, c[1], c[0]} ;
        cfg[2] = 1'b1;
        cfg[1] = c[1]; cfg[3] = c[2]; cfg[0] = c[0];
        oe_mode = m[1:0]; oe_term = c[3]; pin_in = ~c[0] ^ m[0]; sum_in = c[1] ^ c[3];
        chk(m == 0 ? "R6" : (m == 1 ? "R4" : "R7"));
      end
    tick(); oe_mode = 2'b10; oe_term = 0; pin_in = 1; chk("R7");
    tick(); oe_term = 1; chk("R7");
    tick(); oe_mode = 2'b01; cfg = 4'b0100; chk("R6");

    // R9: preset sets Q on the next edge
    tick(); sum_in = 0; chk("R9");
    tick(); sp_term = 1; chk("R9");
    tick(); sp_term = 0; chk("R9");
    tick(); chk("R9");

    // R10: preload beats preset and sum_in
    tick(); pl_en = 1; pl_val = 0; sp_term = 1; sum_in = 1; chk("R10");
    tick(); pl_val = 1; sum_in = 0; chk("R10");
    tick(); pl_val = 0; chk("R10");
    tick(); pl_en = 0; sp_term = 0; chk("R10");

    // R8: reset term between edges, overriding preset and preload
    tick(); sum_in = 1; chk("R8");
    tick(); cfg[0] = 1; chk("R8");
    tick(); ar_term = 1; sp_term = 1; pl_en = 1; pl_val = 1; chk("R8");
    tick(); chk("R8");
    tick(); ar_term = 0; sp_term = 0; pl_en = 0; chk("R8");
    tick(); chk("R8");

    // R11: buried register keeps loading in combinatorial mode
    tick(); cfg = 4'b0110; oe_mode = 2'b01; chk("R11");
    for (int i = 0; i < 10; i++) begin
      tick(); sum_in = (i % 3) == 0; chk("R11");
    end
    tick(); cfg = 4'b1110; pin_in = 1; oe_mode = 2'b00; chk("R11");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule